// File: doc/BRIEF.md
# Telephony Codec Powerdown Sequencer

This block is the digital control core of a telephony codec. It holds a gain/command register and a side-channel register. It decides when the codec is powered down. Four causes lead to powerdown: a fixed power-on hold counted in data clocks, the data clock stopping high, a command bit pair in the gain register, and a direct-mode control line held high. Whatever the cause, the block shuts the serial data driver, gates the logic clock and removes analog power. The side-channel outputs stay under register control the whole time.

All logic runs on a free-running reference clock. The data clock is synchronised into that domain and used through its edges. Control words shift in MSB first on data-clock rising edges while the active-low frame strobe is low. A two-bit mode input selects what happens: 2'b01 (single) loads only the gain register, 2'b10 (dual) loads the gain register and then the side-channel register, and 2'b00 or 2'b11 (direct) loads nothing and watches the control line for a held-high level.

Top module: `codec_pd_ctl`

## Requirements
- R1: While `rst` is high and in the cycle after it, the gain register reads 0xC0 and the side-channel register reads 0. So `gain_adj`=0, `sd_out`=0, `test_en`=0 and `pwr_down`=1.
- R2: For the first 25 data-clock rising edges after reset, serial words are ignored and both registers keep their reset values.
- R3: In mode 2'b01 or 2'b10, with `frame_n` low, the first 8 bits of a frame are written into the gain register, MSB first. `gain_adj` shows its bits 5:0.
- R4: In mode 2'b10, bits 9 to 16 of the frame go to the side-channel register, and `sd_out` shows their low 6 bits. Mode 2'b01 never changes that register. Bits after the last counted bit are ignored. A frame that ends before its 8th bit writes nothing.
- R5: Side-channel bits 2:0 choose a test path: 3'b101 gives `test_en`=001 (transmit filter), 3'b110 gives 010 (receive filter), 3'b111 gives 100 (codec), and any other value gives 000.
- R6: Gain register bits 7:6 equal to 2'b11 force `pwr_down`=1. Any other value leaves `pwr_down`=0 when no other cause is active.
- R7: When `pwr_down`=1, the outputs `dso_oe`, `core_clk_en` and `ana_en` are all 0. Otherwise they are all 1.
- R8: During a command powerdown, the side-channel register can still be written, and `sd_out` and `test_en` follow it.
- R9: In direct mode, `ctl_in` sampled high on 8 consecutive data-clock rising edges sets `pwr_down`. A low sample clears it again. Neither register changes.
- R10: When no data-clock falling edge arrives for LOSS_CYC reference cycles (81 by default, about 19.8 µs at 4.096 MHz), both registers are forced to their reset values. Powerdown therefore remains after the clock returns, until the gain register is rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; clocks all state |
| rst | input | 1 | Synchronous active-high power-on reset |
| dclk | input | 1 | Data clock, asynchronous to ref_clk |
| frame_n | input | 1 | Frame strobe, low during a control word |
| ctl_in | input | 1 | Serial control input |
| mode_sel | input | 2 | 00/11 direct, 01 single-register, 10 dual-register |
| gain_adj | output | 6 | Gain adjust bits of the gain register |
| sd_out | output | 6 | Side-channel outputs |
| test_en | output | 3 | One-hot test path enables |
| pwr_down | output | 1 | Merged powerdown state |
| dso_oe | output | 1 | Serial data output driver enable (0 = high impedance) |
| core_clk_en | output | 1 | Clock enable for the bulk of the logic |
| ana_en | output | 1 | Analog power enable; 0 ties the analog output to ground |

## Verification
A corrupted gain register shows up on `gain_adj`, or as a wrong `pwr_down` level, three reference cycles after the data-clock edge that wrote it. A stuck power-on or high-level counter shows up as a frame that is accepted or refused one data-clock bit early or late. A wrong clock-loss counter moves the moment `pwr_down` rises while the data clock is held high. The bench checks before and after that window, so the error is seen within one check interval. A test-path decode error appears on `test_en` right after the side-channel write.

// File: rtl/codec_pd_ctl_pkg.sv
package codec_pd_ctl_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [1:0] {
        MODE_DIRECT     = 2'b00,
        MODE_SINGLE     = 2'b01,
        MODE_DUAL       = 2'b10,
        MODE_DIRECT_ALT = 2'b11
    } ctl_mode_e;

    typedef struct packed {
        logic [1:0] pd_cmd;
        logic [5:0] gain;
    } gain_reg_t;

    localparam gain_reg_t GAIN_RST = '{pd_cmd: 2'b11, gain: 6'd0};
    localparam logic [5:0] SIDE_RST = 6'd0;

    localparam logic [2:0] PATH_TX    = 3'b101;
    localparam logic [2:0] PATH_RX    = 3'b110;
    localparam logic [2:0] PATH_CODEC = 3'b111;

    function automatic logic is_reg_mode(ctl_mode_e m);
        return (m == MODE_SINGLE) || (m == MODE_DUAL);
    endfunction

    function automatic logic [2:0] path_onehot(logic [2:0] sel);
        case (sel)
            PATH_TX:    return 3'b001;
            PATH_RX:    return 3'b010;
            PATH_CODEC: return 3'b100;
            default:    return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/ccs_dclk_sync.sv
module ccs_dclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic dclk_in,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], dclk_in};
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/ccs_loss_det.sv
module ccs_loss_det #(
    parameter int LOSS_CYC = 81
) (
    input  logic clk,
    input  logic rst,
    input  logic fall,
    output logic lost
);
    localparam int CW = $clog2(LOSS_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || fall)    cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign lost = (cnt == LIMIT);
endmodule

// File: rtl/ccs_serial_rx.sv
module ccs_serial_rx
    import codec_pd_ctl_pkg::*;
#(
    parameter int STUCK_BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              rise,
    input  logic              frame_n,
    input  logic              ctl_in,
    input  ctl_mode_e         mode,
    output logic              wr_a,
    output logic              wr_b,
    output logic [WORD_W-1:0] wr_data,
    output logic              stuck
);
    localparam int BCW = $clog2(2 * WORD_W + 1);
    localparam logic [BCW-1:0] LAST_A = BCW'(WORD_W - 1);
    localparam logic [BCW-1:0] LAST_B = BCW'(2 * WORD_W - 1);
    localparam logic [BCW-1:0] BIT_MAX = BCW'(2 * WORD_W);
    localparam int HCW = $clog2(STUCK_BITS + 1);
    localparam logic [HCW-1:0] HI_MAX = HCW'(STUCK_BITS);

    logic [WORD_W-1:0] shreg;
    logic [BCW-1:0]    bit_cnt;
    logic [HCW-1:0]    hi_cnt;
    logic              reg_mode;
    logic              take;

    assign reg_mode = is_reg_mode(mode);
    assign take     = rise && !frame_n && reg_mode && !hold && (bit_cnt != BIT_MAX);
    assign wr_data  = {shreg[WORD_W-2:0], ctl_in};
    assign wr_a     = take && (bit_cnt == LAST_A);
    assign wr_b     = take && (bit_cnt == LAST_B) && (mode == MODE_DUAL);

    always_ff @(posedge clk) begin
        if (rst || hold || frame_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (take) begin
            shreg   <= wr_data;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold || reg_mode) hi_cnt <= '0;
        else if (rise) begin
            if (!ctl_in)              hi_cnt <= '0;
            else if (hi_cnt != HI_MAX) hi_cnt <= hi_cnt + 1'b1;
        end
    end

    assign stuck = (hi_cnt == HI_MAX);
endmodule

// File: rtl/codec_pd_ctl.sv
module codec_pd_ctl
    import codec_pd_ctl_pkg::*;
#(
    parameter int REF_KHZ    = 4096,
    parameter int LOSS_US    = 20,
    parameter int HOLD_CYC   = 25,
    parameter int STUCK_BITS = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       ref_clk,
    input  logic       rst,
    input  logic       dclk,
    input  logic       frame_n,
    input  logic       ctl_in,
    input  logic [1:0] mode_sel,
    output logic [5:0] gain_adj,
    output logic [5:0] sd_out,
    output logic [2:0] test_en,
    output logic       pwr_down,
    output logic       dso_oe,
    output logic       core_clk_en,
    output logic       ana_en
);
    localparam int LOSS_CYC = REF_KHZ * LOSS_US / 1000;
    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_END = HW'(HOLD_CYC);

    logic              d_rise, d_fall;
    logic              lost, stuck, wr_a, wr_b;
    logic [WORD_W-1:0] wr_data;
    logic [HW-1:0]     hold_cnt;
    logic              in_hold;
    gain_reg_t         reg_a;
    logic [5:0]        reg_b;

    ccs_dclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(ref_clk), .rst(rst), .dclk_in(dclk), .rise(d_rise), .fall(d_fall)
    );

    ccs_loss_det #(.LOSS_CYC(LOSS_CYC)) u_loss (
        .clk(ref_clk), .rst(rst), .fall(d_fall), .lost(lost)
    );

    ccs_serial_rx #(.STUCK_BITS(STUCK_BITS)) u_rx (
        .clk(ref_clk), .rst(rst), .hold(in_hold), .rise(d_rise),
        .frame_n(frame_n), .ctl_in(ctl_in), .mode(ctl_mode_e'(mode_sel)),
        .wr_a(wr_a), .wr_b(wr_b), .wr_data(wr_data), .stuck(stuck)
    );

    always_ff @(posedge ref_clk) begin
        if (rst)                               hold_cnt <= '0;
        else if (d_rise && hold_cnt != HOLD_END) hold_cnt <= hold_cnt + 1'b1;
    end
    assign in_hold = (hold_cnt != HOLD_END);

    always_ff @(posedge ref_clk) begin
        if (rst || in_hold || lost) begin
            reg_a <= GAIN_RST;
            reg_b <= SIDE_RST;
        end else begin
            if (wr_a) reg_a <= gain_reg_t'(wr_data);
            if (wr_b) reg_b <= wr_data[5:0];
        end
    end

    assign pwr_down    = in_hold | lost | stuck | (reg_a.pd_cmd == 2'b11);
    assign gain_adj    = reg_a.gain;
    assign sd_out      = reg_b;
    assign test_en     = path_onehot(reg_b[2:0]);
    assign dso_oe      = ~pwr_down;
    assign core_clk_en = ~pwr_down;
    assign ana_en      = ~pwr_down;
endmodule

// File: rtl/codec_pd_ctl_chk.sv
module codec_pd_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_hold,
    input logic       lost,
    input logic       stuck,
    input logic       wr_a,
    input logic [5:0] gain_adj,
    input logic [5:0] sd_out,
    input logic [2:0] test_en,
    input logic       pwr_down
);
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pwr_down && gain_adj == 6'd0 && sd_out == 6'd0)); // R1

    AST_HOLD_KEEPS_REGS: assert property (@(posedge clk) disable iff (rst)
        in_hold |-> (pwr_down && gain_adj == 6'd0 && sd_out == 6'd0)); // R2

    AST_GAIN_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!wr_a && !in_hold && !lost) |=> $stable(gain_adj)); // R3

    AST_TEST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(test_en)); // R5

    AST_STUCK_KEEPS_GAIN: assert property (@(posedge clk) disable iff (rst)
        (stuck && !lost) |=> $stable(gain_adj)); // R9

    AST_LOSS_FORCES_RST: assert property (@(posedge clk) disable iff (rst)
        lost |=> (pwr_down && gain_adj == 6'd0 && sd_out == 6'd0)); // R10
endmodule

bind codec_pd_ctl codec_pd_ctl_chk u_chk (
    .clk(ref_clk), .rst(rst), .in_hold(in_hold), .lost(lost), .stuck(stuck),
    .wr_a(wr_a), .gain_adj(gain_adj), .sd_out(sd_out), .test_en(test_en),
    .pwr_down(pwr_down)
);

// File: tb/codec_pd_ctl_tb.sv
module codec_pd_ctl_tb;
    localparam int REF_PERIOD = 10;
    localparam int DHALF = 4 * REF_PERIOD;

    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic       dclk = 1'b0;
    logic       frame_n = 1'b1;
    logic       ctl_in = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic [5:0] gain_adj, sd_out;
    logic [2:0] test_en;
    logic       pwr_down, dso_oe, core_clk_en, ana_en;

    codec_pd_ctl u_dut (
        .ref_clk(ref_clk), .rst(rst), .dclk(dclk), .frame_n(frame_n),
        .ctl_in(ctl_in), .mode_sel(mode_sel), .gain_adj(gain_adj),
        .sd_out(sd_out), .test_en(test_en), .pwr_down(pwr_down),
        .dso_oe(dso_oe), .core_clk_en(core_clk_en), .ana_en(ana_en)
    );

    always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

    typedef struct packed {
        logic [5:0] gain;
        logic [5:0] sd;
        logic [2:0] tst;
        logic       pd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    // monitor: pops each expected item and compares it away from the edge
    initial begin
        forever begin
            @(negedge ref_clk);
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                logic  ok;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_run++;
                ok = (gain_adj == e.gain) && (sd_out == e.sd) && (test_en == e.tst)
                     && (pwr_down == e.pd) && (dso_oe == !e.pd)
                     && (core_clk_en == !e.pd) && (ana_en == !e.pd);
                if (!ok) begin
                    n_fail++;
                    $display("FAIL %s: got gain=%h sd=%h tst=%b pd=%b oe=%b clk=%b ana=%b exp gain=%h sd=%h tst=%b pd=%b",
                             t, gain_adj, sd_out, test_en, pwr_down, dso_oe, core_clk_en, ana_en,
                             e.gain, e.sd, e.tst, e.pd);
                end
            end
        end
    end

    task automatic expect_out(input string t, input logic [5:0] g, input logic [5:0] s,
                              input logic [2:0] x, input logic p);
        exp_q.push_back('{gain: g, sd: s, tst: x, pd: p});
        tag_q.push_back(t);
        wait (exp_q.size() == 0);
        @(posedge ref_clk);
        #7;
    endtask

    task automatic dbit(input logic fr, input logic b);
        frame_n = fr;
        ctl_in  = b;
        #(DHALF) dclk = 1'b1;
        #(DHALF) dclk = 1'b0;
    endtask

    task automatic send_word(input logic [1:0] m, input logic [15:0] data, input int n);
        mode_sel = m;
        dbit(1'b1, 1'b0);
        for (int i = 0; i < n; i++) dbit(1'b0, data[15 - i]);
        dbit(1'b1, 1'b0);
    endtask

    initial begin
        #(REF_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge ref_clk);
        expect_out("R1 reset held", 6'h00, 6'h00, 3'b000, 1'b1);
        @(negedge ref_clk) rst = 1'b0;
        expect_out("R1 after reset", 6'h00, 6'h00, 3'b000, 1'b1);

        // R2: full frames during the 25-edge hold are discarded
        mode_sel = 2'b10;
        for (int i = 0; i < 25; i++) dbit(1'b0, (8'h15 >> (7 - (i % 8))) & 1'b1);
        expect_out("R2 hold ignores words", 6'h00, 6'h00, 3'b000, 1'b1);

        send_word(2'b01, {8'h15, 8'h00}, 8);
        expect_out("R3 single write", 6'h15, 6'h00, 3'b000, 1'b0);

        send_word(2'b10, {8'h2A, 8'h25}, 16);
        expect_out("R4 dual write / R5 tx path", 6'h2A, 6'h25, 3'b001, 1'b0);
        send_word(2'b10, {8'h2A, 8'h06}, 16);
        expect_out("R5 rx path", 6'h2A, 6'h06, 3'b010, 1'b0);
        send_word(2'b10, {8'h2A, 8'h07}, 16);
        expect_out("R5 codec path", 6'h2A, 6'h07, 3'b100, 1'b0);
        send_word(2'b10, {8'h2A, 8'h03}, 16);
        expect_out("R5 normal path", 6'h2A, 6'h03, 3'b000, 1'b0);

        send_word(2'b01, {8'h11, 8'hFF}, 8);
        expect_out("R4 single leaves side reg", 6'h11, 6'h03, 3'b000, 1'b0);

        mode_sel = 2'b01;
        dbit(1'b1, 1'b0);
        for (int i = 0; i < 5; i++) dbit(1'b0, 1'b1);
        dbit(1'b1, 1'b0);
        expect_out("R4 short frame writes nothing", 6'h11, 6'h03, 3'b000, 1'b0);

        mode_sel = 2'b10;
        dbit(1'b1, 1'b0);
        for (int i = 0; i < 16; i++) dbit(1'b0, (16'h0901 >> (15 - i)) & 1'b1);
        for (int i = 0; i < 4; i++) dbit(1'b0, 1'b1);
        dbit(1'b1, 1'b0);
        expect_out("R4 trailing bits ignored", 6'h09, 6'h01, 3'b000, 1'b0);

        send_word(2'b01, {8'hC3, 8'h00}, 8);
        expect_out("R6 command powerdown / R7", 6'h03, 6'h01, 3'b000, 1'b1);
        send_word(2'b10, {8'hC3, 8'h2D}, 16);
        expect_out("R8 side reg writable in powerdown", 6'h03, 6'h2D, 3'b001, 1'b1);
        send_word(2'b01, {8'h40, 8'h00}, 8);
        expect_out("R6 command released", 6'h00, 6'h2D, 3'b001, 1'b0);

        mode_sel = 2'b00;
        for (int i = 0; i < 7; i++) dbit(1'b1, 1'b1);
        expect_out("R9 seven high bits", 6'h00, 6'h2D, 3'b001, 1'b0);
        dbit(1'b1, 1'b1);
        expect_out("R9 eighth high bit", 6'h00, 6'h2D, 3'b001, 1'b1);
        dbit(1'b1, 1'b0);
        expect_out("R9 low bit clears", 6'h00, 6'h2D, 3'b001, 1'b0);

        send_word(2'b01, {8'h15, 8'h00}, 8);
        expect_out("R3 rewrite before loss", 6'h15, 6'h2D, 3'b001, 1'b0);

        // R10: data clock stops high
        #(DHALF) dclk = 1'b1;
        #(40 * REF_PERIOD);
        expect_out("R10 inside window", 6'h15, 6'h2D, 3'b001, 1'b0);
        #(100 * REF_PERIOD);
        expect_out("R10 clock lost", 6'h00, 6'h00, 3'b000, 1'b1);
        for (int i = 0; i < 3; i++) dbit(1'b1, 1'b0);
        expect_out("R10 clock back stays down", 6'h00, 6'h00, 3'b000, 1'b1);
        send_word(2'b01, {8'h15, 8'h00}, 8);
        expect_out("R10 rewrite exits", 6'h15, 6'h00, 3'b000, 1'b0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule